// File: doc/BRIEF.md
# Region freeze bridge controller

This block isolates a reconfigurable region of logic from the static part of a chip. Software drives it through a small word-addressed register port. It writes a one-hot request into a control word and then polls a status word until the matching handshake has finished. The block drives three things:

- a freeze output, which gates the traffic that crosses the region boundary;
- a reset output into the region;
- drain and resume requests, which the region acknowledges.

A freeze moves through two steps. The block first asks the region to drain. After the region acknowledges, the block asserts the freeze output and reports freeze-done. An unfreeze moves through three steps. The block releases the region reset, then drops the freeze output and asks the region to resume. After the region acknowledges, it reports unfreeze-done. The block does not act on a request that does not fit its current state. Instead it records the condition in a sticky register that software clears by writing a one. A fixed version word lets software identify the block.

Top module: `region_freeze_ctrl`

## Requirements
- R1: After reset the status word reads 2 (unfreeze-done set, freeze-done clear). The control and illegal words read 0. freezeOut, regionReset, freezeReq and unfreezeReq are all low.
- R2: Reads are combinational from addr. Offset 0 is status (bit 0 freeze-done, bit 1 unfreeze-done). Offset 4 returns the last word written to control. Offset 8 is the illegal word. Offset 12 returns 0xAD000003. Every other address, including misaligned ones, reads 0.
- R3: Writing control value 1 while unfreeze-done is set raises freezeReq from the next cycle, with status reading 0. The region then acknowledges: on the clock edge where regionAck is high, freezeReq drops, freezeOut rises and status reads 1.
- R4: Writing control value 4 while freeze-done is set proceeds in three steps:
  - On the next cycle regionReset is low, freezeOut is still high and status reads 0.
  - One cycle later freezeOut is low and unfreezeReq is high.
  - After the edge on which regionAck is high, status reads 2 and unfreezeReq is low.
- R5: Writing control value 2 while freeze-done is set raises regionReset on the next cycle. regionReset then stays high until an unfreeze is accepted.
- R6: Writing control value 0 changes neither the status nor any output.
- R7: A freeze request that arrives while unfreeze-done is clear, or an unfreeze request that arrives while freeze-done is clear, sets illegal bit 0. The block takes no other action.
- R8: A control write with more than one of bits 2:0 set sets illegal bit 1. The block takes no other action.
- R9: A reset request (control value 2) that arrives while freeze-done is clear sets illegal bit 2. regionReset stays low.
- R10: Illegal bits are sticky. A write to offset 8 with bit 0 set clears them all. A write to offset 8 with bit 0 clear leaves them unchanged.
- R11: At most one of freeze-done and unfreeze-done is set at any time. freezeOut is high whenever freeze-done is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register access |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for addr (combinational) |
| freezeOut | output | 1 | Gates boundary traffic while high |
| regionReset | output | 1 | Reset into the region |
| freezeReq | output | 1 | Asks the region to drain |
| unfreezeReq | output | 1 | Asks the region to resume |
| regionAck | input | 1 | Region acknowledges the pending request |

## Verification
The properties assume that regionAck is high only while freezeReq or unfreezeReq is outstanding. They also assume that register writes come as single-cycle strobes with a stable address. The bench raises regionAck for exactly one cycle, and only after it has seen the matching request output. It holds wrEn for one clock and drives addr and wrData on the falling edge. The properties on zero writes are limited to the two settled states. In those states no acknowledge can move the state machine, so the only thing that could disturb the state is the write itself.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_DRAIN  = 3'd1,
    ST_FROZEN = 3'd2,
    ST_RELRST = 3'd3,
    ST_RESUME = 3'd4
  } frzState_e;

  // Requests decoded from a control-word write.
  typedef struct packed {
    logic freeze;
    logic unfreeze;
    logic reset;
    logic multi;
  } reqDecode_t;

  // Strobes and status the control FSM hands to the datapath.
  typedef struct packed {
    logic illState;
    logic illMulti;
    logic illReset;
    logic frzDone;
    logic unfrzDone;
  } ctrlStrobe_t;

  localparam int unsigned ILL_W = 3;
  localparam int unsigned REQ_W = 3;
endpackage

// File: rtl/rfb_datapath.sv
module rfb_datapath
  import rfb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter logic [DATA_W-1:0] VERSION = 32'hAD000003
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  ctrlStrobe_t       strobe,
  output reqDecode_t        req,
  output logic [ILL_W-1:0]  illReg,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CTRL   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_ILL    = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_VER    = ADDR_W'(12);

  logic [DATA_W-1:0] ctrlReg;
  logic [REQ_W-1:0]  reqBits;
  logic              ctrlWr;
  logic              illClr;
  logic [ILL_W-1:0]  illSet;

  assign ctrlWr  = wrEn && (addr == OFS_CTRL);
  assign illClr  = wrEn && (addr == OFS_ILL) && wrData[0];
  assign reqBits = wrData[REQ_W-1:0];

  always_comb begin
    req          = '0;
    req.freeze   = ctrlWr && (reqBits == 3'b001);
    req.reset    = ctrlWr && (reqBits == 3'b010);
    req.unfreeze = ctrlWr && (reqBits == 3'b100);
    req.multi    = ctrlWr && ($countones(reqBits) > 1);
  end

  assign illSet = {strobe.illReset, strobe.illMulti, strobe.illState};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      illReg  <= '0;
    end else begin
      if (ctrlWr) ctrlReg <= wrData;
      if (illClr) illReg <= illSet;
      else        illReg <= illReg | illSet;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      OFS_STATUS: rdData = DATA_W'({strobe.unfrzDone, strobe.frzDone});
      OFS_CTRL:   rdData = ctrlReg;
      OFS_ILL:    rdData = DATA_W'(illReg);
      OFS_VER:    rdData = VERSION;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/rfb_ctrl.sv
module rfb_ctrl
  import rfb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  reqDecode_t  req,
  input  logic        regionAck,
  output ctrlStrobe_t strobe,
  output logic        freezeOut,
  output logic        regionReset,
  output logic        freezeReq,
  output logic        unfreezeReq
);
  frzState_e state, nextState;
  logic      rstSet, rstClr;

  always_comb begin
    nextState       = state;
    rstSet          = 1'b0;
    rstClr          = 1'b0;
    strobe          = '0;
    strobe.illMulti = req.multi;
    case (state)
      ST_DRAIN:  if (regionAck) nextState = ST_FROZEN;
      ST_RELRST: nextState = ST_RESUME;
      ST_RESUME: if (regionAck) nextState = ST_RUN;
      default:   ;
    endcase
    if (req.freeze) begin
      if (state == ST_RUN) nextState = ST_DRAIN;
      else                 strobe.illState = 1'b1;
    end
    if (req.unfreeze) begin
      if (state == ST_FROZEN) begin
        nextState = ST_RELRST;
        rstClr    = 1'b1;
      end else begin
        strobe.illState = 1'b1;
      end
    end
    if (req.reset) begin
      if (state == ST_FROZEN) rstSet = 1'b1;
      else                    strobe.illReset = 1'b1;
    end
    strobe.frzDone   = (state == ST_FROZEN);
    strobe.unfrzDone = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_RUN;
      regionReset <= 1'b0;
    end else begin
      state <= nextState;
      if (rstClr)      regionReset <= 1'b0;
      else if (rstSet) regionReset <= 1'b1;
    end
  end

  assign freezeOut   = (state == ST_FROZEN) || (state == ST_RELRST);
  assign freezeReq   = (state == ST_DRAIN);
  assign unfreezeReq = (state == ST_RESUME);
endmodule

// File: rtl/region_freeze_ctrl.sv
module region_freeze_ctrl
  import rfb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter logic [DATA_W-1:0] VERSION = 32'hAD000003
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              freezeOut,
  output logic              regionReset,
  output logic              freezeReq,
  output logic              unfreezeReq,
  input  logic              regionAck
);
  reqDecode_t       req;
  ctrlStrobe_t      strobe;
  logic [ILL_W-1:0] illReg;
  logic             frzDone;
  logic             unfrzDone;

  assign frzDone   = strobe.frzDone;
  assign unfrzDone = strobe.unfrzDone;

  rfb_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .VERSION(VERSION)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .addr  (addr),
    .wrData(wrData),
    .strobe(strobe),
    .req   (req),
    .illReg(illReg),
    .rdData(rdData)
  );

  rfb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .req        (req),
    .regionAck  (regionAck),
    .strobe     (strobe),
    .freezeOut  (freezeOut),
    .regionReset(regionReset),
    .freezeReq  (freezeReq),
    .unfreezeReq(unfreezeReq)
  );
endmodule

// File: rtl/rfb_checker.sv
module rfb_checker #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [2:0]        wrLow,
  input logic              freezeOut,
  input logic              regionReset,
  input logic              freezeReq,
  input logic              frzDone,
  input logic              unfrzDone,
  input logic [2:0]        illReg
);
  logic ctrlWr, illClr;
  assign ctrlWr = wrEn && (addr == ADDR_W'(4));
  assign illClr = wrEn && (addr == ADDR_W'(8)) && wrLow[0];

  a_r11_status_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({frzDone, unfrzDone}));

  a_r11_frozen_gates: assert property (@(posedge clk) disable iff (!rstN)
    frzDone |-> freezeOut);

  a_r5_reset_needs_freeze: assert property (@(posedge clk) disable iff (!rstN)
    regionReset |-> freezeOut);

  a_r3_drain_not_done: assert property (@(posedge clk) disable iff (!rstN)
    freezeReq |-> (!frzDone && !unfrzDone && !freezeOut));

  a_r4_release_first: assert property (@(posedge clk) disable iff (!rstN)
    $fell(regionReset) |-> freezeOut);

  a_r6_zero_write_stable: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && (wrLow == 3'b000) && (frzDone || unfrzDone)) |=>
      $stable({frzDone, unfrzDone, regionReset, freezeOut}));

  a_r7_wrong_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && (wrLow == 3'b001) && !unfrzDone) |=> illReg[0]);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!illClr && (illReg != 3'b000)) |=> ((illReg & $past(illReg)) == $past(illReg)));
endmodule

bind region_freeze_ctrl rfb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .addr       (addr),
  .wrLow      (wrData[2:0]),
  .freezeOut  (freezeOut),
  .regionReset(regionReset),
  .freezeReq  (freezeReq),
  .frzDone    (frzDone),
  .unfrzDone  (unfrzDone),
  .illReg     (illReg)
);

// File: tb/tb_region_freeze_ctrl.sv
module tb_region_freeze_ctrl;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              freezeOut, regionReset, freezeReq, unfreezeReq;
  logic              regionAck = 1'b0;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  region_freeze_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .freezeOut(freezeOut), .regionReset(regionReset),
    .freezeReq(freezeReq), .unfreezeReq(unfreezeReq), .regionAck(regionAck)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic ackPulse();
    @(negedge clk);
    regionAck = 1'b1;
    @(negedge clk);
    regionAck = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v);  chk("R1 status", v, 32'h2);
    rd(4, v);  chk("R1 ctrl", v, 0);
    rd(8, v);  chk("R1 illegal", v, 0);
    chk("R1 outputs", {freezeOut, regionReset, freezeReq, unfreezeReq}, 0);
    rd(12, v); chk("R2 version", v, 32'hAD000003);
    rd(2, v);  chk("R2 misaligned", v, 0);
    rd(15, v); chk("R2 unmapped", v, 0);
  endtask

  task automatic t_freeze();
    logic [31:0] v;
    wr(4, 32'h1);
    chk("R3 freezeReq", freezeReq, 1);
    chk("R3 no gate yet", freezeOut, 0);
    rd(0, v); chk("R3 status draining", v, 0);
    rd(4, v); chk("R2 ctrl readback", v, 32'h1);
    wr(4, 0);
    chk("R6 zero write while draining", freezeReq, 1);
    ackPulse();
    rd(0, v); chk("R3 status frozen", v, 32'h1);
    chk("R3 gate", freezeOut, 1);
    chk("R3 req drop", freezeReq, 0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    wr(4, 0);
    rd(0, v); chk("R6 status unchanged", v, 32'h1);
    chk("R6 outputs unchanged", {freezeOut, regionReset, freezeReq, unfreezeReq}, 4'b1000);
    rd(8, v); chk("R6 no illegal", v, 0);
  endtask

  task automatic t_resetReq();
    wr(4, 32'h2);
    chk("R5 reset asserted", regionReset, 1);
    wr(4, 0);
    chk("R5 reset held", regionReset, 1);
  endtask

  task automatic t_unfreeze();
    logic [31:0] v;
    wr(4, 32'h4);
    chk("R4 reset released", regionReset, 0);
    chk("R4 gate still on", freezeOut, 1);
    rd(0, v); chk("R4 status busy", v, 0);
    @(negedge clk);
    chk("R4 gate off", freezeOut, 0);
    chk("R4 unfreezeReq", unfreezeReq, 1);
    @(negedge clk);
    rd(0, v); chk("R4 waits for ack", v, 0);
    ackPulse();
    rd(0, v); chk("R4 status run", v, 32'h2);
    chk("R4 req drop", unfreezeReq, 0);
  endtask

  task automatic t_illegalState();
    logic [31:0] v;
    wr(4, 32'h4);
    rd(8, v); chk("R7 unfreeze in run", v, 32'h1);
    rd(0, v); chk("R7 status kept", v, 32'h2);
    wr(8, 0);
    rd(8, v); chk("R10 sticky on zero write", v, 32'h1);
    wr(8, 1);
    rd(8, v); chk("R10 cleared", v, 0);
  endtask

  task automatic t_multi();
    logic [31:0] v;
    wr(4, 32'h3);
    rd(8, v); chk("R8 multi bit", v, 32'h2);
    chk("R8 no drain", freezeReq, 0);
    rd(0, v); chk("R8 status kept", v, 32'h2);
    wr(8, 1);
  endtask

  task automatic t_resetUnfrozen();
    logic [31:0] v;
    wr(4, 32'h2);
    rd(8, v); chk("R9 reset while run", v, 32'h4);
    chk("R9 no region reset", regionReset, 0);
    wr(8, 1);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    wr(4, 32'h1);
    wr(4, 32'h1);
    rd(8, v); chk("R7 freeze while draining", v, 32'h1);
    ackPulse();
    rd(0, v); chk("R11 frozen after busy", v, 32'h1);
    chk("R11 gate with done", freezeOut, 1);
    wr(8, 1);
    wr(4, 32'h4);
    @(negedge clk);
    ackPulse();
    rd(0, v); chk("R4 back to run", v, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_freeze();
    t_zero();
    t_resetReq();
    t_unfreeze();
    t_illegalState();
    t_multi();
    t_resetUnfrozen();
    t_busy();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule